// File: doc/BRIEF.md
# Chip Erase Sequencer

This block runs a whole-array erase one block at a time. A one-cycle `start` pulse launches it. The block first checks the programming-voltage flag and the protection state of every block. It then walks the block indices from 0 upward and sends each block that may be erased to a per-block eraser over a request/acknowledge handshake. Blocks that are locked are passed over without raising an error. A boot block is also passed over while write protection is active.

The run ends in one of four ways:
- the last index has been visited;
- the eraser reports a failure, and no later block is touched;
- the voltage is too low at start;
- no block is erasable at all.

In every case `busy` falls and `done` pulses for one cycle. The `status` byte shows the outcome in a fixed bit layout. A suspend request is accepted on a pin so that it can be wired in, but it never changes the run.

Top module: `chip_erase_seq`

## Requirements
- R1: After reset, `busy`, `done` and `ers_req` are 0 and `status` reads 0x80.
- R2: Only erasable blocks are requested. A block with its `lock_bits` bit set is skipped, and the skip leaves no error bit behind.
- R3: Blocks are requested in strictly ascending index order, one at a time. No new request is made before the previous one is acknowledged.
- R4: Blocks 0 and 1 are boot blocks (parameter `BOOT_MAP` = 0b11). A boot block is erasable only when `wp_hi` is 1 and its lock bit is 0. Any other block needs only a clear lock bit.
- R5: If `ers_fail` is 1 in the cycle `ers_ack` is 1, the run ends in the next cycle. No further block is requested. `status` bit 5 is set, and bits 3 and 1 stay clear.
- R6: If no block is erasable when `start` is taken, the block makes no request and `status` ends at 0xA2 (bits 7, 5, 1).
- R7: If `vpp_low` is 1 when `start` is taken, the block makes no request and `status` ends at 0xA8 (bits 7, 5, 3). This check takes precedence over R6.
- R8: `suspend_req` has no effect. The block sequence and the cycle count are identical with or without it.
- R9: `busy` is 1 from the cycle after `start` until the last block finishes. `done` is 1 for exactly one cycle, in which `busy` is 0. `status` bit 7 always equals the inverse of `busy`.
- R10: `start` is ignored while a run is in progress. The error bits of `status` hold until the next accepted `start`, which clears them.
- R11: `ers_req` stays 1 and `ers_blk` stays stable until the cycle in which `ers_ack` is 1. `ers_req` then drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse, taken only while idle |
| vpp_low | input | 1 | Programming voltage at or below the lockout level |
| wp_hi | input | 1 | Write protection released (1 lets boot blocks be erased) |
| suspend_req | input | 1 | Suspend request, ignored |
| lock_bits | input | NUM_BLK | Per-block lock bits, 1 = locked |
| ers_req | output | 1 | Request to the block eraser |
| ers_blk | output | BLK_W | Index of the block to erase |
| ers_ack | input | 1 | One-cycle completion from the eraser |
| ers_fail | input | 1 | Failure flag, valid together with `ers_ack` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 8 | Bit 7 ready, bit 5 erase error, bit 3 voltage error, bit 1 lock error |

## Verification
The bench targets the boot blocks while write protection is active. A design that ignored `wp_hi` would erase blocks 0 and 1, and one that blocked every block would raise a lock error. It injects a failure in the middle of the array. A sequencer that kept going after the failure would log blocks beyond the failing one, or would leave the error bit clear. It sets both the voltage flag and a fully locked array at once, so that the wrong precedence shows up as 0xA2 in place of 0xA8. It pulses `start` again in the middle of a run and compares runs with and without `suspend_req`. A restart would repeat low indices, and a suspend that took effect would stretch the cycle count.

// File: rtl/ces_pkg.sv
package ces_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2,
    ST_FIN  = 2'd3
  } ces_state_t;

  localparam int SR_READY = 7;
  localparam int SR_ERASE = 5;
  localparam int SR_VPP   = 3;
  localparam int SR_LOCK  = 1;

  // A block may be erased when unlocked, and a boot block also needs protection released.
  function automatic logic blk_erasable(input logic is_boot, input logic locked,
                                        input logic wp_release);
    return !locked && (!is_boot || wp_release);
  endfunction

  function automatic logic idx_is_last(input int unsigned idx, input int unsigned nblk);
    return idx == (nblk - 1);
  endfunction

  function automatic logic [7:0] pack_status(input logic ready, input logic e_erase,
                                             input logic e_vpp, input logic e_lock);
    logic [7:0] s;
    s = 8'h00;
    s[SR_READY] = ready;
    s[SR_ERASE] = e_erase;
    s[SR_VPP]   = e_vpp;
    s[SR_LOCK]  = e_lock;
    return s;
  endfunction

endpackage

// File: rtl/ces_eligibility.sv
module ces_eligibility #(
  parameter int unsigned NUM_BLK = 8,
  parameter logic [NUM_BLK-1:0] BOOT_MAP = '0
) (
  input  logic [NUM_BLK-1:0] lock_bits,
  input  logic               wp_hi,
  output logic [NUM_BLK-1:0] elig_vec,
  output logic               any_elig
);
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    assign elig_vec[g] = ces_pkg::blk_erasable(BOOT_MAP[g], lock_bits[g], wp_hi);
  end

  assign any_elig = |elig_vec;
endmodule

// File: rtl/ces_ctrl.sv
module ces_ctrl #(
  parameter int unsigned NUM_BLK = 8,
  parameter int unsigned BLK_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             vpp_low,
  input  logic             any_elig,
  input  logic             cur_elig,
  input  logic             ers_ack,
  input  logic             ers_fail,
  output logic [BLK_W-1:0] blk_idx,
  output logic             ers_req,
  output logic             busy,
  output logic             done,
  output logic             ev_accept,
  output logic             ev_vpp,
  output logic             ev_locked,
  output logic             ev_fail
);
  import ces_pkg::*;

  ces_state_t state;
  logic       at_last;

  assign at_last   = idx_is_last(int'(blk_idx), NUM_BLK);
  assign ev_accept = (state == ST_IDLE) && start;
  assign ev_vpp    = ev_accept && vpp_low;
  assign ev_locked = ev_accept && !vpp_low && !any_elig;
  assign ev_fail   = (state == ST_WAIT) && ers_ack && ers_fail;
  assign busy      = (state == ST_SCAN) || (state == ST_WAIT);
  assign done      = (state == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      blk_idx <= '0;
      ers_req <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            blk_idx <= '0;
            state   <= (vpp_low || !any_elig) ? ST_FIN : ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (cur_elig) begin
            ers_req <= 1'b1;
            state   <= ST_WAIT;
          end else if (at_last) begin
            state <= ST_FIN;
          end else begin
            blk_idx <= blk_idx + 1'b1;
          end
        end
        ST_WAIT: begin
          if (ers_ack) begin
            ers_req <= 1'b0;
            if (ers_fail || at_last) begin
              state <= ST_FIN;
            end else begin
              blk_idx <= blk_idx + 1'b1;
              state   <= ST_SCAN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ces_status.sv
module ces_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       ev_accept,
  input  logic       ev_vpp,
  input  logic       ev_locked,
  input  logic       ev_fail,
  output logic [7:0] status
);
  logic err_erase, err_vpp, err_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_erase <= 1'b0;
      err_vpp   <= 1'b0;
      err_lock  <= 1'b0;
    end else if (ev_accept) begin
      err_erase <= ev_vpp | ev_locked;
      err_vpp   <= ev_vpp;
      err_lock  <= ev_locked;
    end else if (ev_fail) begin
      err_erase <= 1'b1;
    end
  end

  assign status = ces_pkg::pack_status(!busy, err_erase, err_vpp, err_lock);
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq #(
  parameter int unsigned NUM_BLK = 8,
  parameter logic [NUM_BLK-1:0] BOOT_MAP = NUM_BLK'(2'b11),
  localparam int unsigned BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               vpp_low,
  input  logic               wp_hi,
  input  logic               suspend_req,
  input  logic [NUM_BLK-1:0] lock_bits,
  output logic               ers_req,
  output logic [BLK_W-1:0]   ers_blk,
  input  logic               ers_ack,
  input  logic               ers_fail,
  output logic               busy,
  output logic               done,
  output logic [7:0]         status
);
  logic [NUM_BLK-1:0] elig_vec;
  logic               any_elig;
  logic               cur_elig;
  logic               ev_accept, ev_vpp, ev_locked, ev_fail;

  ces_eligibility #(.NUM_BLK(NUM_BLK), .BOOT_MAP(BOOT_MAP)) u_elig (
    .lock_bits(lock_bits),
    .wp_hi    (wp_hi),
    .elig_vec (elig_vec),
    .any_elig (any_elig)
  );

  assign cur_elig = elig_vec[ers_blk];

  ces_ctrl #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vpp_low  (vpp_low),
    .any_elig (any_elig),
    .cur_elig (cur_elig),
    .ers_ack  (ers_ack),
    .ers_fail (ers_fail),
    .blk_idx  (ers_blk),
    .ers_req  (ers_req),
    .busy     (busy),
    .done     (done),
    .ev_accept(ev_accept),
    .ev_vpp   (ev_vpp),
    .ev_locked(ev_locked),
    .ev_fail  (ev_fail)
  );

  ces_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .ev_accept(ev_accept),
    .ev_vpp   (ev_vpp),
    .ev_locked(ev_locked),
    .ev_fail  (ev_fail),
    .status   (status)
  );
endmodule

// File: rtl/ces_checker.sv
module ces_checker #(
  parameter int unsigned NUM_BLK = 8,
  parameter int unsigned BLK_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               vpp_low,
  input logic               suspend_req,
  input logic               busy,
  input logic               done,
  input logic               req,
  input logic               ack,
  input logic               fail,
  input logic [BLK_W-1:0]   blk,
  input logic               sts_erase,
  input logic               sts_vpp,
  input logic [NUM_BLK-1:0] elig_vec
);
  logic [BLK_W-1:0] last_blk;
  logic             have_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_blk  <= '0;
      have_last <= 1'b0;
    end else if (!busy) begin
      have_last <= 1'b0;
    end else if (req && ack) begin
      last_blk  <= blk;
      have_last <= 1'b1;
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  assert_blk_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> $stable(blk));
  assert_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req);
  assert_req_erasable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> elig_vec[blk]);
  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req) && have_last) |-> (blk > last_blk));
  assert_fail_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && fail) |=> (!busy && !req && sts_erase));
  assert_vpp_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && vpp_low) |=> (sts_vpp && sts_erase && done && !busy));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_req_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);
  assert_suspend_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_req && req && !ack) |=> req);
endmodule

bind chip_erase_seq ces_checker #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_ces_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .vpp_low    (vpp_low),
  .suspend_req(suspend_req),
  .busy       (busy),
  .done       (done),
  .req        (ers_req),
  .ack        (ers_ack),
  .fail       (ers_fail),
  .blk        (ers_blk),
  .sts_erase  (status[5]),
  .sts_vpp    (status[3]),
  .elig_vec   (elig_vec)
);

// File: tb/chip_erase_seq_bench.sv
`timescale 1ns/1ps
module chip_erase_seq_bench;
  localparam int NB  = 8;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, vpp_low = 1'b0, wp_hi = 1'b1, suspend_req = 1'b0;
  logic [NB-1:0] lock_bits = '0;
  logic          ers_req, ers_ack = 1'b0, ers_fail = 1'b0;
  logic [2:0]    ers_blk;
  logic          busy, done;
  logic [7:0]    status;

  int errors = 0, checks = 0;
  int log_blk[16];
  int log_n = 0;
  int wait_cnt = 0;
  bit fail_en = 0;
  int fail_blk = 0;

  always #2.5 clk = ~clk;

  chip_erase_seq u_chip_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vpp_low(vpp_low), .wp_hi(wp_hi),
    .suspend_req(suspend_req), .lock_bits(lock_bits), .ers_req(ers_req),
    .ers_blk(ers_blk), .ers_ack(ers_ack), .ers_fail(ers_fail),
    .busy(busy), .done(done), .status(status)
  );

  // Eraser model: acknowledges after LAT cycles and logs the block.
  always @(negedge clk) begin
    if (ers_ack) begin
      ers_ack  = 1'b0;
      ers_fail = 1'b0;
    end else if (ers_req) begin
      if (wait_cnt == LAT) begin
        ers_ack  = 1'b1;
        ers_fail = fail_en && (int'(ers_blk) == fail_blk);
        if (log_n < 16) log_blk[log_n] = int'(ers_blk);
        log_n++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit bench_erasable(input int i, input logic [NB-1:0] lk, input bit wp);
    if (lk[i]) return 0;
    if (i < 2 && !wp) return 0;
    return 1;
  endfunction

  task automatic run_case(input string tag, input logic [NB-1:0] lk, input bit wp,
                          input bit vpp, input bit susp, input bit fen, input int fblk,
                          input bit restart_try, output int cycles);
    int exp_q[NB];
    int exp_n = 0;
    bit none = 1;
    bit stopped = 0;
    bit ready_bad = 0;
    int exp_sts;
    int cyc;
    for (int i = 0; i < NB; i++) begin
      if (bench_erasable(i, lk, wp)) begin
        none = 0;
        if (!stopped && !vpp) begin
          exp_q[exp_n] = i;
          exp_n++;
          if (fen && i == fblk) stopped = 1;
        end
      end
    end
    if (vpp) exp_sts = 8'hA8;
    else if (none) exp_sts = 8'hA2;
    else if (stopped) exp_sts = 8'hA0;
    else exp_sts = 8'h80;

    @(negedge clk);
    lock_bits = lk; wp_hi = wp; vpp_low = vpp; suspend_req = susp;
    fail_en = fen; fail_blk = fblk; log_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == !(vpp || none), {tag, " R9 busy after start"}, busy, !(vpp || none));
    while (!done && cyc < 500) begin
      start = restart_try && (cyc == 3);
      if (status[7] != !busy) ready_bad = 1;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done == 1'b1, {tag, " R9 done seen"}, done, 1);
    check(!ready_bad && status[7] == 1'b1, {tag, " R9 ready bit"}, status[7], 1);
    check(status == exp_sts[7:0], {tag, " R5/R6/R7 status"}, status, exp_sts);
    @(negedge clk);
    check(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
    check(status == exp_sts[7:0], {tag, " R10 status held"}, status, exp_sts);
    check(log_n == exp_n, {tag, " R2/R3 block count"}, log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++)
      check(log_blk[k] == exp_q[k], {tag, " R3 block order"}, log_blk[k], exp_q[k]);
    suspend_req = 1'b0;
    fail_en = 0;
    cycles = cyc;
  endtask

  task automatic test_reset();
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(ers_req == 0, "R1 req", ers_req, 0);
    check(status == 8'h80, "R1 status", status, 8'h80);
  endtask

  task automatic test_all_open();
    int c;
    run_case("all-open R2", 8'h00, 1, 0, 0, 0, 0, 0, c);
  endtask

  task automatic test_some_locked();
    int c;
    run_case("locked-skip R2", 8'h54, 1, 0, 0, 0, 0, 0, c);
  endtask

  task automatic test_boot_protect();
    int c;
    run_case("boot-wp R4", 8'h00, 0, 0, 0, 0, 0, 0, c);
    run_case("boot-wp-lock R4", 8'h81, 1, 0, 0, 0, 0, 0, c);
  endtask

  task automatic test_fail_mid();
    int c;
    run_case("fail R5", 8'h04, 1, 0, 0, 1, 3, 0, c);
  endtask

  task automatic test_all_locked();
    int c;
    run_case("all-locked R6", 8'hFF, 1, 0, 0, 0, 0, 0, c);
    run_case("wp-locked R6", 8'hFC, 0, 0, 0, 0, 0, 0, c);
  endtask

  task automatic test_vpp();
    int c;
    run_case("vpp R7", 8'hFF, 1, 1, 0, 0, 0, 0, c);
    run_case("vpp-open R7", 8'h00, 1, 1, 0, 0, 0, 0, c);
  endtask

  task automatic test_suspend();
    int c1, c2;
    run_case("nosusp R8", 8'h54, 1, 0, 0, 0, 0, 0, c1);
    run_case("susp R8", 8'h54, 1, 0, 1, 0, 0, 0, c2);
    check(c1 == c2, "R8 suspend cycle count", c2, c1);
  endtask

  task automatic test_restart_and_clear();
    int c;
    run_case("restart R10", 8'h00, 1, 0, 0, 0, 0, 1, c);
    run_case("pre-clear R10", 8'h00, 1, 0, 0, 1, 1, 0, c);
    run_case("clear R10", 8'h10, 1, 0, 0, 0, 0, 0, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_all_open();
    test_some_locked();
    test_boot_protect();
    test_fail_mid();
    test_all_locked();
    test_vpp();
    test_suspend();
    test_restart_and_clear();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule